// File: doc/BRIEF.md
# Filter Gate Request/Status Controller

This block opens and closes the entry gates of up to four memory access filters. Software controls it through one 32-bit word on a simple write/read port. It writes the open or closed state it wants for each filter into the lower half of the word. The upper half shows the state each gate has actually reached. The two halves differ for a while after every change, and software polls until they agree.

Opening a gate takes effect on the cycle after the request is seen. Closing a gate is a two-step handshake. First the filter stops accepting new transactions. Then the gate stays reported as open until that filter's outstanding-transaction count reaches zero, and only then does its status bit clear. If the request comes back before the filter has drained, the gate returns to accepting traffic and never reports closed. Because requests and status sit in separate fields, software can change one filter with a read-modify-write and leave the others alone.

Top module: `filter_gatekeeper`

## Requirements
- R1: After reset, `reg_rdata`, `gate_open` and `accept_new` are all zero.
- R2: A write (`reg_wr` high at a clock edge) stores `reg_wdata[n]` as the request for filter n, for every n below `NUM_FILT`. The request reads back in `reg_rdata[n]` after that edge.
- R3: `reg_wdata[15:NUM_FILT]` and `reg_wdata[31:16]` are ignored. `reg_rdata[15:NUM_FILT]` and `reg_rdata[31:16+NUM_FILT]` always read zero.
- R4: `reg_rdata[16+n]` always equals `gate_open[n]`.
- R5: If filter n's request is set while its gate is closed, `gate_open[n]` and `accept_new[n]` rise at the second clock edge after the write edge, never at the write edge itself.
- R6: If filter n's request is cleared while its gate is open, `accept_new[n]` falls at the second clock edge after the write edge, while `gate_open[n]` stays high. `accept_new[n]` is never high while `gate_open[n]` is low.
- R7: While filter n is draining, `gate_open[n]` clears only at the clock edge at which its `inflight_cnt` field (bits `n*CNT_W` upward) is zero. With a zero count, this is the third edge after the write edge.
- R8: If filter n's request is set again while it is draining, `accept_new[n]` rises at the next edge and `gate_open[n]` never falls.
- R9: A read-modify-write that changes one filter's request leaves the request bits, status bits and outputs of every other filter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data; bits [NUM_FILT-1:0] are requests |
| reg_rdata | output | 32 | Read data: {status half, request half} |
| inflight_cnt | input | NUM_FILT*CNT_W | Outstanding transactions per filter, filter n at bits n*CNT_W upward |
| gate_open | output | NUM_FILT | Actual gate state per filter |
| accept_new | output | NUM_FILT | Filter may admit new transactions |

## Verification
A filter stuck in the wrong internal state becomes visible at the ports within one or two edges, because every state drives a distinct pair of `gate_open` and `accept_new` values. A gate that skips draining clears its status while the bench still holds a non-zero count. A gate that stalls in draining keeps its status bit set one edge after the count reaches zero. A corrupted request bit shows up in the lower half of `reg_rdata` right after the write edge, and in a neighbouring filter's outputs after a read-modify-write.

// File: rtl/gk_pkg.sv
package gk_pkg;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    GK_SHUT  = 2'd0,
    GK_PASS  = 2'd1,
    GK_DRAIN = 2'd2
  } gk_state_e;

  // Ones in the positions of implemented filters.
  function automatic logic [HALF_W-1:0] impl_mask(input int nfilt);
    logic [HALF_W-1:0] m;
    m = '0;
    for (int i = 0; i < HALF_W; i++) if (i < nfilt) m[i] = 1'b1;
    return m;
  endfunction

  // Control word layout: status in the upper half, requests in the lower half.
  function automatic logic [2*HALF_W-1:0] pack_word(input logic [HALF_W-1:0] stat,
                                                    input logic [HALF_W-1:0] req);
    return {stat, req};
  endfunction
endpackage

// File: rtl/gk_req_reg.sv
module gk_req_reg #(
  parameter int NUM_FILT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [NUM_FILT-1:0] req_q
);
  // Bits beyond the implemented requests are dropped on purpose.
  logic unused_wr_bits;
  assign unused_wr_bits = ^wr_data[31:NUM_FILT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     req_q <= '0;
    else if (wr_en) req_q <= wr_data[NUM_FILT-1:0];
  end
endmodule

// File: rtl/gk_gate.sv
module gk_gate
  import gk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] cnt,
  output logic             open_o,
  output logic             accept_o
);
  gk_state_e state, state_nx;
  logic      drained;

  assign drained = (cnt == '0);

  always_comb begin
    state_nx = state;
    unique case (state)
      GK_SHUT:  if (req) state_nx = GK_PASS;
      GK_PASS:  if (!req) state_nx = GK_DRAIN;
      GK_DRAIN: if (req) state_nx = GK_PASS;
                else if (drained) state_nx = GK_SHUT;
      default:  state_nx = GK_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= GK_SHUT;
    else        state <= state_nx;
  end

  assign open_o   = (state != GK_SHUT);
  assign accept_o = (state == GK_PASS);

  p_open_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GK_SHUT && req) |=> (open_o && accept_o));

  p_stop_new_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !accept_o);

  p_accept_needs_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |-> open_o);

  p_close_after_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_o) |-> ($past(drained) && !$past(req)));

  p_reopen_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == GK_DRAIN && req) |=> (open_o && accept_o));
endmodule

// File: rtl/filter_gatekeeper.sv
module filter_gatekeeper
  import gk_pkg::*;
#(
  parameter int NUM_FILT = 4,
  parameter int CNT_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [31:0]               reg_wdata,
  output logic [31:0]               reg_rdata,
  input  logic [NUM_FILT*CNT_W-1:0] inflight_cnt,
  output logic [NUM_FILT-1:0]       gate_open,
  output logic [NUM_FILT-1:0]       accept_new
);
  localparam logic [HALF_W-1:0] IMPL = impl_mask(NUM_FILT);

  logic [NUM_FILT-1:0] req_q;
  logic [HALF_W-1:0]   req_w, stat_w;

  gk_req_reg #(.NUM_FILT(NUM_FILT)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr),
    .wr_data (reg_wdata),
    .req_q   (req_q)
  );

  for (genvar n = 0; n < NUM_FILT; n++) begin : g_gate
    gk_gate #(.CNT_W(CNT_W)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_q[n]),
      .cnt      (inflight_cnt[n*CNT_W +: CNT_W]),
      .open_o   (gate_open[n]),
      .accept_o (accept_new[n])
    );
  end

  always_comb begin
    req_w  = '0;
    stat_w = '0;
    req_w[NUM_FILT-1:0]  = req_q;
    stat_w[NUM_FILT-1:0] = gate_open;
  end

  assign reg_rdata = pack_word(stat_w, req_w);

  p_req_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_rdata[HALF_W-1:0] == ($past(reg_wdata[HALF_W-1:0]) & IMPL)));
endmodule

// File: tb/filter_gatekeeper_tb.sv
module filter_gatekeeper_tb;
  localparam int NF = 4;
  localparam int CW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_wr = 0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NF*CW-1:0] inflight_cnt = '0;
  logic [NF-1:0] gate_open, accept_new;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  filter_gatekeeper #(.NUM_FILT(NF), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .inflight_cnt(inflight_cnt),
    .gate_open(gate_open), .accept_new(accept_new)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // Drives one write; returns at the negedge after the write edge.
  task automatic bus_write(input logic [31:0] d);
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic set_cnt(input int f, input int v);
    inflight_cnt[f*CW +: CW] = CW'(v);
  endtask

  task automatic t_reset;
    check("R1 rdata", reg_rdata, 32'h0);
    check("R1 gate_open", 32'(gate_open), 32'h0);
    check("R1 accept_new", 32'(accept_new), 32'h0);
  endtask

  task automatic t_open;
    bus_write(32'hFFFF_FFF1);
    check("R2 request readback", reg_rdata[15:0], 32'h0001);
    check("R3 ignored bits", {reg_rdata[31:20], 16'h0, reg_rdata[15:4]}, 32'h0);
    check("R5 no early open", 32'(gate_open), 32'h0);
    tick(1);
    check("R5 gate_open", 32'(gate_open), 32'h1);
    check("R5 accept_new", 32'(accept_new), 32'h1);
    check("R4 status mirror", reg_rdata, 32'h0001_0001);
  endtask

  task automatic t_rmw;
    logic [31:0] w;
    w = (reg_rdata & 32'h0000_FFFF) | 32'h4;
    bus_write(w);
    tick(1);
    check("R9 rmw open filter2", 32'(gate_open), 32'h5);
    check("R9 rmw word", reg_rdata, 32'h0005_0005);
    bus_write(32'hF);
    tick(1);
    check("R5 all open", 32'(accept_new), 32'hF);
    check("R4 all status", reg_rdata, 32'h000F_000F);
  endtask

  task automatic t_close_drain;
    set_cnt(1, 3);
    bus_write((reg_rdata & 32'hFFFF) & ~32'h2);
    check("R2 request cleared", reg_rdata, 32'h000F_000D);
    tick(1);
    check("R6 accept stops", 32'(accept_new), 32'hD);
    check("R6 gate still open", 32'(gate_open), 32'hF);
    tick(5);
    check("R7 held while busy", 32'(gate_open), 32'hF);
    set_cnt(1, 0);
    check("R7 not before edge", 32'(gate_open), 32'hF);
    tick(1);
    check("R7 closes after drain", reg_rdata, 32'h000D_000D);
    check("R9 others unchanged", 32'(accept_new), 32'hD);
  endtask

  task automatic t_reopen;
    set_cnt(3, 2);
    bus_write(32'h5);
    tick(1);
    check("R6 filter3 stopped", 32'(accept_new), 32'h5);
    bus_write(32'hD);
    check("R8 status held", 32'(gate_open), 32'hD);
    tick(1);
    check("R8 accept again", 32'(accept_new), 32'hD);
    check("R8 never closed", 32'(gate_open), 32'hD);
    set_cnt(3, 0);
  endtask

  task automatic t_close_zero;
    bus_write(32'hC);
    check("R7 not at write edge", 32'(gate_open), 32'hD);
    tick(1);
    check("R6 filter0 stopped", 32'(accept_new), 32'hC);
    check("R7 draining one edge", 32'(gate_open), 32'hD);
    tick(1);
    check("R7 closed third edge", reg_rdata, 32'h000C_000C);
  endtask

  task automatic t_reset_again;
    rst_n = 1'b0;
    #1;
    t_reset();
    tick(1);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_open();
    t_rmw();
    t_close_drain();
    t_reopen();
    t_close_zero();
    t_reset_again();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule